// File: doc/BRIEF.md
# Cascadable Queue Almost-Full Status Unit

This unit produces the write-side status of one device in a group of up to eight cascaded four-queue flow-control buffers. The queue memories sit outside it and report their word counts as inputs. Each device has a static 3-bit chip identity. A 5-bit write address carries that identity in its upper three bits and a queue index in its lower two bits, so up to 32 queues can be addressed across the group.

The device selected for writing shows the full and almost-full state of its active queue on two discrete active-low flags. Separately, every device can report the almost-full state of all four of its queues on a 4-bit flag bus. The devices share that bus, and only one may drive it at a time. In direct mode, a flag-bus strobe sampled together with the write address picks the device that drives the bus. Every other device releases its bus pins to high impedance.

The bus mode and the almost-full margin are captured while reset is held. A queue counts as almost full when its free space is at or below that margin.

Top module: `qflag_status`

## Requirements
- R1: While reset is held and on the first cycle after it, the device is deselected: `full_n` and `paf_n` are 1 and `af_bus_en` is 0.
- R2: When `wr_addr_load` is 1 and `wr_addr[4:2]` equals `chip_id`, queue `wr_addr[1:0]` becomes the active queue. From the next cycle on, `full_n` and `paf_n` show that queue; they do not change in the cycle of the load.
- R3: When `wr_addr_load` is 1 and `wr_addr[4:2]` differs from `chip_id`, the device deselects itself. From the next cycle on, `full_n` and `paf_n` are both 1 whatever the counts are.
- R4: While the device is selected, `full_n` is 0 exactly when the active queue's count is at least DEPTH (256 by default).
- R5: While the device is selected, `paf_n` is 0 exactly when the active queue's count plus the margin captured from `af_gap` during reset is at least DEPTH.
- R6: While the device drives the bus, bit i of `af_bus` is the active-low almost-full state of queue i, under the same rule as R5. The first queue is on bit 0 and the fourth queue is on bit 3.
- R7: In direct mode (`flag_mode_direct` held at 1 during reset), a `flag_strobe` with `wr_addr[4:2]` equal to `chip_id` makes the device drive `af_bus` from the next cycle. `af_bus_en` goes to 1 and stays there until the next strobe.
- R8: A `flag_strobe` with a different identity in `wr_addr[4:2]` releases the bus from the next cycle. Among devices with distinct identities, at most one drives at any time.
- R9: In polled mode (`flag_mode_direct` held at 0 during reset), the device never drives `af_bus`.
- R10: Each strobe acts on one thing only. Without `flag_strobe`, bus ownership is unchanged. Without `wr_addr_load`, the queue selection is unchanged. A change of `wr_addr` alone affects neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode and margin are captured while low |
| chip_id | input | 3 | Static identity of this device in the cascade |
| flag_mode_direct | input | 1 | 1 selects direct bus ownership, 0 polled; captured during reset |
| af_gap | input | 9 | Almost-full margin in words; captured during reset |
| wr_addr | input | 5 | Write address: identity in [4:2], queue in [1:0] |
| wr_addr_load | input | 1 | Loads a new write queue selection from `wr_addr` |
| flag_strobe | input | 1 | Loads flag-bus ownership from `wr_addr[4:2]` |
| q_count | input | 36 | Four 9-bit queue word counts, queue i at bits [9i+8:9i] |
| full_n | output | 1 | Active-low full flag of the active write queue |
| paf_n | output | 1 | Active-low almost-full flag of the active write queue |
| af_bus | output | 4 | Per-queue active-low almost-full bus, high impedance when released |
| af_bus_en | output | 1 | 1 while this device drives `af_bus` |

## Verification
The properties take the chip identity, the mode input and the margin to be static after reset. The mode check reads `flag_mode_direct` directly rather than the captured copy, so a mode input that changed after reset would break that assumption. The bench therefore sets these inputs before reset and never changes them. It runs three devices with distinct identities, one of them in polled mode. All three see the same address and strobes, exactly as on a shared board. The bench counts every cycle in which more than one bus enable is high. Queue counts change only between clock edges, and the checks sample them at the falling edge.

// File: rtl/qflag_pkg.sv
// Package: shared constants and types for the cascadable queue status unit.
// Assumes four queues per device and up to eight devices in a cascade.
package qflag_pkg;
    localparam int QSEL_W = 2;   // queue index bits in the write address
    localparam int ID_W   = 3;   // chip identity bits in the write address

    // Bus ownership mode captured during reset.
    typedef enum logic {
        OWN_POLLED = 1'b0,
        OWN_DIRECT = 1'b1
    } own_mode_e;
endpackage

// File: rtl/qflag_level_cmp.sv
// Module: compares one queue's word count against the full depth and the
// almost-full margin. Assumes count never exceeds DEPTH. Pure combinational.
module qflag_level_cmp #(
    parameter int DEPTH = 256,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] gap,
    output logic          is_full,
    output logic          is_almost
);
    localparam int SW = CW + 1;   // one extra bit so count + gap cannot wrap

    logic [SW-1:0] reach;

    // Purpose: derive the full and almost-full levels of one queue.
    always_comb begin
        reach     = SW'(count) + SW'(gap);
        is_full   = (SW'(count) >= SW'(DEPTH));
        is_almost = (reach >= SW'(DEPTH));
    end
endmodule

// File: rtl/qflag_wr_select.sv
// Module: holds the write-side selection. A load whose identity field matches
// this chip selects the addressed queue; any other load deselects the device.
// Assumes chip_id is static after reset.
module qflag_wr_select #(
    parameter int QSEL_W = 2,
    parameter int ID_W   = 3,
    parameter int AW     = QSEL_W + ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   chip_id,
    input  logic [AW-1:0]     wr_addr,
    input  logic              wr_addr_load,
    output logic              dev_sel,
    output logic [QSEL_W-1:0] act_q
);
    logic id_hit;

    // Purpose: compare the identity field of the address with this chip.
    always_comb id_hit = (wr_addr[AW-1 -: ID_W] == chip_id);

    // Purpose: register the selection on each address load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_sel <= 1'b0;
            act_q   <= '0;
        end else if (wr_addr_load) begin
            dev_sel <= id_hit;
            if (id_hit) begin
                act_q <= wr_addr[QSEL_W-1:0];
            end
        end
    end
endmodule

// File: rtl/qflag_bus_owner.sv
// Module: decides whether this device drives the shared almost-full bus.
// In direct mode a flag strobe hands the bus to the chip named by the
// identity field. In polled mode the device never takes the bus.
// Assumes every device in the cascade sees the same strobe and address.
module qflag_bus_owner #(
    parameter int ID_W = 3,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_direct,
    input  logic [ID_W-1:0] chip_id,
    input  logic [AW-1:0]   wr_addr,
    input  logic            flag_strobe,
    output logic            own
);
    logic id_hit;

    // Purpose: compare the identity field of the address with this chip.
    always_comb id_hit = (wr_addr[AW-1 -: ID_W] == chip_id);

    // Purpose: take or release the bus on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own <= 1'b0;
        end else if (flag_strobe) begin
            own <= id_hit & mode_direct;
        end
    end
endmodule

// File: rtl/qflag_status.sv
// Module: top of the write-side status unit of one cascadable four-queue
// device. It captures the mode and the margin while reset is held, evaluates
// every queue's level, multiplexes the active queue onto the discrete flags
// and drives the shared per-queue almost-full bus when it owns it.
// Assumes the queue counts come from registers in the queue memories.
module qflag_status
    import qflag_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int QW    = QSEL_W,
    parameter int IW    = ID_W,
    parameter int NQ    = 1 << QW,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int AW    = QW + IW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    chip_id,
    input  logic             flag_mode_direct,
    input  logic [CW-1:0]    af_gap,
    input  logic [AW-1:0]    wr_addr,
    input  logic             wr_addr_load,
    input  logic             flag_strobe,
    input  logic [NQ*CW-1:0] q_count,
    output logic             full_n,
    output logic             paf_n,
    output tri   [NQ-1:0]    af_bus,
    output logic             af_bus_en
);
    own_mode_e         mode_q;
    logic [CW-1:0]     gap_q;
    logic [NQ-1:0]     q_full;
    logic [NQ-1:0]     q_almost;
    logic              dev_sel;
    logic [QW-1:0]     act_q;
    logic              own;

    // Purpose: capture the bus mode and the almost-full margin during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= own_mode_e'(flag_mode_direct);
            gap_q  <= af_gap;
        end
    end

    // Purpose: one level comparator per queue.
    for (genvar gi = 0; gi < NQ; gi++) begin : g_cmp
        qflag_level_cmp #(.DEPTH(DEPTH), .CW(CW)) u_cmp (
            .count     (q_count[gi*CW +: CW]),
            .gap       (gap_q),
            .is_full   (q_full[gi]),
            .is_almost (q_almost[gi])
        );
    end

    qflag_wr_select #(.QSEL_W(QW), .ID_W(IW), .AW(AW)) u_wsel (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_id      (chip_id),
        .wr_addr      (wr_addr),
        .wr_addr_load (wr_addr_load),
        .dev_sel      (dev_sel),
        .act_q        (act_q)
    );

    qflag_bus_owner #(.ID_W(IW), .AW(AW)) u_own (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_direct (mode_q == OWN_DIRECT),
        .chip_id     (chip_id),
        .wr_addr     (wr_addr),
        .flag_strobe (flag_strobe),
        .own         (own)
    );

    // Purpose: show the active queue on the discrete flags, inactive when deselected.
    always_comb begin
        full_n = ~(dev_sel & q_full[act_q]);
        paf_n  = ~(dev_sel & q_almost[act_q]);
    end

    // Purpose: drive the shared bus only while owned, otherwise release it.
    assign af_bus_en = own;
    assign af_bus    = own ? ~q_almost : {NQ{1'bz}};
endmodule

// File: rtl/qflag_status_chk.sv
// Module: property checker for qflag_status, attached with a bind.
// Assumes chip_id and flag_mode_direct are static after reset.
module qflag_status_chk #(
    parameter int IW = 3,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [IW-1:0] chip_id,
    input logic          flag_mode_direct,
    input logic [AW-1:0] wr_addr,
    input logic          wr_addr_load,
    input logic          flag_strobe,
    input logic          full_n,
    input logic          paf_n,
    input logic          af_bus_en
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (full_n && paf_n && !af_bus_en));

    // R3
    deselect_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr_load && (wr_addr[AW-1 -: IW] != chip_id)) |=> (full_n && paf_n));

    // R7
    take_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_strobe && flag_mode_direct && (wr_addr[AW-1 -: IW] == chip_id)) |=> af_bus_en);

    // R8
    release_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_strobe && (wr_addr[AW-1 -: IW] != chip_id)) |=> !af_bus_en);

    // R9
    polled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_mode_direct |-> !af_bus_en);

    // R10
    own_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_strobe |=> $stable(af_bus_en));
endmodule

bind qflag_status qflag_status_chk #(.IW(IW), .AW(AW)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .chip_id          (chip_id),
    .flag_mode_direct (flag_mode_direct),
    .wr_addr          (wr_addr),
    .wr_addr_load     (wr_addr_load),
    .flag_strobe      (flag_strobe),
    .full_n           (full_n),
    .paf_n            (paf_n),
    .af_bus_en        (af_bus_en)
);

// File: tb/qflag_status_bench.sv
module qflag_status_bench;
    localparam int DEPTH = 256;
    localparam int CW    = 9;
    localparam int NQ    = 4;
    localparam int GAP   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] wr_addr = '0;
    logic wr_addr_load = 1'b0;
    logic flag_strobe = 1'b0;
    logic [NQ*CW-1:0] cnt = '0;
    logic full_n, paf_n, en_main;
    logic full_p0, paf_p0, en_p0;
    logic full_p1, paf_p1, en_p1;
    wire  [NQ-1:0] bus_main, bus_p0, bus_p1;
    int errors = 0;
    int checks = 0;
    int overlap = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    qflag_status u_qflag_status (
        .clk(clk), .rst_n(rst_n), .chip_id(3'd5), .flag_mode_direct(1'b1),
        .af_gap(9'(GAP)), .wr_addr(wr_addr), .wr_addr_load(wr_addr_load),
        .flag_strobe(flag_strobe), .q_count(cnt), .full_n(full_n), .paf_n(paf_n),
        .af_bus(bus_main), .af_bus_en(en_main));

    qflag_status u_peer0 (
        .clk(clk), .rst_n(rst_n), .chip_id(3'd2), .flag_mode_direct(1'b1),
        .af_gap(9'(GAP)), .wr_addr(wr_addr), .wr_addr_load(wr_addr_load),
        .flag_strobe(flag_strobe), .q_count(cnt), .full_n(full_p0), .paf_n(paf_p0),
        .af_bus(bus_p0), .af_bus_en(en_p0));

    qflag_status u_peer1 (
        .clk(clk), .rst_n(rst_n), .chip_id(3'd7), .flag_mode_direct(1'b0),
        .af_gap(9'(GAP)), .wr_addr(wr_addr), .wr_addr_load(wr_addr_load),
        .flag_strobe(flag_strobe), .q_count(cnt), .full_n(full_p1), .paf_n(paf_p1),
        .af_bus(bus_p1), .af_bus_en(en_p1));

    // R8: count cycles in which two devices drive the shared bus together.
    always @(negedge clk) begin
        if (rst_n && (int'(en_main) + int'(en_p0) + int'(en_p1) > 1)) overlap++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_cnt(input int q, input int val);
        cnt[q*CW +: CW] = 9'(val);
    endtask

    // Drive a one-cycle strobe at a falling edge; result is visible at the next falling edge.
    task automatic do_load(input logic [4:0] a);
        wr_addr = a; wr_addr_load = 1'b1;
        @(negedge clk);
        wr_addr_load = 1'b0;
    endtask

    task automatic do_strobe(input logic [4:0] a);
        wr_addr = a; flag_strobe = 1'b1;
        @(negedge clk);
        flag_strobe = 1'b0;
    endtask

    task automatic t_reset();
        set_cnt(0, 256);
        repeat (3) @(negedge clk);
        check("R1", {full_n, paf_n, en_main}, 3'b110, "flags during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {full_n, paf_n, en_main, en_p0, en_p1}, 5'b11000, "idle after reset");
    endtask

    task automatic t_select();
        set_cnt(0, 256); set_cnt(1, 240); set_cnt(2, 239); set_cnt(3, 0);
        wr_addr = {3'd5, 2'd0}; wr_addr_load = 1'b1;
        #1;
        check("R2", {full_n, paf_n}, 2'b11, "no change in load cycle");
        @(negedge clk);
        wr_addr_load = 1'b0;
        check("R2", {full_n, paf_n}, 2'b00, "queue 0 full");
        do_load({3'd5, 2'd1});
        check("R2", {full_n, paf_n}, 2'b10, "queue 1 almost full");
        do_load({3'd5, 2'd2});
        check("R2", {full_n, paf_n}, 2'b11, "queue 2 below margin");
        do_load({3'd5, 2'd3});
        check("R2", {full_n, paf_n}, 2'b11, "queue 3 empty");
    endtask

    task automatic t_levels();
        // queue 3 stays active from t_select
        set_cnt(3, 239); #1;
        check("R5", paf_n, 1'b1, "count 239 margin 16");
        set_cnt(3, 240); #1;
        check("R5", paf_n, 1'b0, "count 240 margin 16");
        set_cnt(3, 255); #1;
        check("R4", full_n, 1'b1, "count 255");
        set_cnt(3, 256); #1;
        check("R4", full_n, 1'b0, "count 256");
        set_cnt(3, 0);
        @(negedge clk);
    endtask

    task automatic t_deselect();
        do_load({3'd2, 2'd0});
        check("R3", {full_n, paf_n}, 2'b11, "main deselected with full queue 0");
        check("R3", {full_p0, paf_p0}, 2'b00, "peer selected queue 0");
        wr_addr = {3'd5, 2'd1};
        repeat (2) @(negedge clk);
        check("R10", {full_n, paf_n, full_p0, paf_p0}, 4'b1100, "address change without load");
        do_strobe({3'd5, 2'd0});
        check("R10", {full_n, paf_n}, 2'b11, "flag strobe leaves selection");
    endtask

    task automatic t_bus();
        // main owns after the strobe in t_deselect; counts: 256,240,239,0
        check("R7", {en_main, en_p0, en_p1}, 3'b100, "main owns bus");
        check("R6", bus_main, 4'b1100, "per-queue almost-full bits");
        set_cnt(2, 250); #1;
        check("R6", bus_main, 4'b1000, "queue 2 reaches margin");
        do_load({3'd2, 2'd1});
        check("R10", en_main, 1'b1, "address load leaves ownership");
        repeat (3) @(negedge clk);
        check("R7", en_main, 1'b1, "ownership holds without strobe");
        do_strobe({3'd2, 2'd3});
        check("R8", {en_main, en_p0, en_p1}, 3'b010, "hand-over to peer");
        check("R6", bus_p0, 4'b1000, "peer bus value");
        do_strobe({3'd7, 2'd0});
        check("R9", {en_main, en_p0, en_p1}, 3'b000, "polled device stays off");
        do_strobe({3'd5, 2'd2});
        check("R7", en_main, 1'b1, "main retakes bus");
        do_strobe({3'd1, 2'd2});
        check("R8", {en_main, en_p0, en_p1}, 3'b000, "unused identity releases all");
        check("R8", overlap, 0, "cycles with two drivers");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_select();
                t_levels();
                t_deselect();
                t_bus();
                done = 1'b1;
            end
            begin
                repeat (5000) @(negedge clk);
                if (!done) begin
                    errors++; checks++;
                    $display("FAIL R1 watchdog: actual=timeout expected=done");
                end
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule